// File: doc/BRIEF.md
# Shared Bus Arbiter with Selectable Priority Scheme

This block sits between several bus masters and the single bus they share. Each master raises its own request line when it wants the bus. The arbiter picks exactly one master and raises that master's grant line. It then holds a busy flag high for as long as that master keeps its request up. A two-bit mode input chooses how the winner is picked. The choices are a rotating order that shifts on every decision, a least-recently-used order, and a pseudo-random pick driven by a linear feedback shift register.

A decision is taken only on a clock edge where the bus is free: no grant is outstanding, busy is low, and at least one request is high. The grant is registered, so it appears in the cycle after that edge. The master releases the bus by dropping its request. On that edge the grant and busy both clear, and the next decision can follow one edge later. The mode input is sampled only at decision edges, so a tenure that is already running is never affected by a mode change.

Top module: `shared_bus_arbiter`

## Requirements
- R1: While synchronous reset is high, and in the first cycle after it, grant is all zero and busy is low.
- R2: A decision is taken on a rising edge where busy is low, grant is zero and at least one request bit is high. From the next cycle, grant is one-hot and selects a master whose request was high at that edge.
- R3: No new grant is issued, and the present grant does not change, while a grant is outstanding or busy is high, whatever the other request lines do.
- R4: The granted master keeps its grant while it holds its request. Busy is low in the first grant cycle and goes high in the cycle after, provided the request is still held.
- R5: When the granted master's request is low at a rising edge, grant and busy both clear on that edge. If the request falls during the first grant cycle, busy never rises.
- R6: Mode 2'b00 is rotating. The highest-priority index starts at 0 after reset, and the remaining order runs upward with wraparound. After each decision taken in this mode, the lowest-ranked index becomes the highest (the top index moves down by one, modulo N), whoever won.
- R7: Mode 2'b01 is least-recently-used. An ordered list starts as 0 (most preferred) through N-1. The first listed index with an active request wins. On every grant, in any mode, the winner moves to the least-preferred end and the others keep their relative order.
- R8: Mode 2'b10 is random. A 16-bit Fibonacci LFSR (taps 16,14,13,11, nonzero seed) advances every clock. Its value modulo N gives a start index, and the first active request found scanning upward from that index with wraparound wins. Every active master can win.
- R9: A change of the mode input during a tenure leaves the grant and busy untouched. The new mode applies from the next decision.
- R10: Mode 2'b11 behaves exactly as the rotating mode and shares its priority state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | Priority scheme: 00 rotating, 01 LRU, 10 random, 11 rotating |
| req_i | input | N_MASTERS | Per-master bus request |
| grant_o | output | N_MASTERS | Registered one-hot bus grant |
| busy_o | output | 1 | Bus tenure in progress |

## Verification
The hardest behaviour to reach from the ports is the way priority state builds up across several tenures. The rotating pointer moves only on rotating-mode decisions, while the LRU list moves on every grant. A bench that only ever drives one mode never sees the two interact. The stimulus therefore runs sequences that switch modes between tenures and uses partial request masks that place the winner away from the top of the order. A reference model of both orders, kept from the requirements, predicts each winner. Separate runs cover a request dropped in the first grant cycle and a mode change in the middle of a tenure.

// File: rtl/arb_pkg.sv
package arb_pkg;

    typedef enum logic [1:0] {
        MODE_ROTATE     = 2'b00,
        MODE_LRU        = 2'b01,
        MODE_RANDOM     = 2'b10,
        MODE_ROTATE_ALT = 2'b11
    } arb_mode_e;

    localparam int          LFSR_W    = 16;
    localparam logic [15:0] LFSR_TAPS = 16'hB400;  // bits 15,13,12,10
    localparam logic [15:0] LFSR_SEED = 16'hACE1;

    function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
        return {s[LFSR_W-2:0], ^(s & LFSR_TAPS)};
    endfunction

    function automatic logic is_rotating(input arb_mode_e m);
        return (m == MODE_ROTATE) || (m == MODE_ROTATE_ALT);
    endfunction

endpackage

// File: rtl/arb_lfsr.sv
module arb_lfsr
    import arb_pkg::*;
#(
    parameter logic [LFSR_W-1:0] SEED = LFSR_SEED
) (
    input  logic              clk,
    input  logic              rst,
    output logic [LFSR_W-1:0] value_o
);
    logic [LFSR_W-1:0] state_q;

    always_ff @(posedge clk) begin
        if (rst) state_q <= SEED;
        else     state_q <= lfsr_step(state_q);
    end

    assign value_o = state_q;

    // R8: a maximal-length register never reaches the all-zero lock-up state
    a_r8_lfsr_nonzero: assert property (@(posedge clk) disable iff (rst)
        state_q != '0);
endmodule

// File: rtl/arb_scan_pick.sv
module arb_scan_pick #(
    parameter int N  = 4,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [IW-1:0] start_i,
    input  logic [N-1:0]  req_i,
    output logic [IW-1:0] idx_o,
    output logic          hit_o
);
    always_comb begin
        idx_o = '0;
        hit_o = 1'b0;
        for (int k = N - 1; k >= 0; k--) begin
            int c;
            c = int'(start_i) + k;
            if (c >= N) c = c - N;
            if (req_i[c]) begin
                idx_o = IW'(c);
                hit_o = 1'b1;
            end
        end
    end
endmodule

// File: rtl/arb_lru_list.sv
module arb_lru_list #(
    parameter int N  = 4,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  req_i,
    input  logic          upd_i,
    input  logic [IW-1:0] win_i,
    output logic [IW-1:0] pick_o,
    output logic          hit_o
);
    logic [IW-1:0] order_q [N];
    logic [IW-1:0] order_d [N];
    int            win_pos;
    logic [N-1:0]  seen_mask;

    // first listed index with an active request
    always_comb begin
        pick_o = '0;
        hit_o  = 1'b0;
        for (int k = N - 1; k >= 0; k--) begin
            if (req_i[order_q[k]]) begin
                pick_o = order_q[k];
                hit_o  = 1'b1;
            end
        end
    end

    // move the winner to the least-preferred end
    always_comb begin
        win_pos = N - 1;
        for (int k = N - 1; k >= 0; k--) begin
            if (order_q[k] == win_i) win_pos = k;
        end
        for (int k = 0; k < N; k++) begin
            if (k == N - 1)       order_d[k] = win_i;
            else if (k < win_pos) order_d[k] = order_q[k];
            else                  order_d[k] = order_q[k+1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < N; k++) order_q[k] <= IW'(k);
        end else if (upd_i) begin
            for (int k = 0; k < N; k++) order_q[k] <= order_d[k];
        end
    end

    always_comb begin
        seen_mask = '0;
        for (int k = 0; k < N; k++) seen_mask[order_q[k]] = 1'b1;
    end

    // R7: the list always holds each index exactly once
    a_r7_lru_permutation: assert property (@(posedge clk) disable iff (rst)
        &seen_mask);
    // R7: the latest winner sits at the least-preferred end
    a_r7_lru_tail: assert property (@(posedge clk) disable iff (rst)
        upd_i |=> order_q[N-1] == $past(win_i));
endmodule

// File: rtl/shared_bus_arbiter.sv
module shared_bus_arbiter
    import arb_pkg::*;
#(
    parameter int N_MASTERS = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [1:0]           mode_i,
    input  logic [N_MASTERS-1:0] req_i,
    output logic [N_MASTERS-1:0] grant_o,
    output logic                 busy_o
);
    localparam int N  = N_MASTERS;
    localparam int IW = (N > 1) ? $clog2(N) : 1;

    arb_mode_e         mode;
    logic [N-1:0]      grant_q;
    logic              busy_q;
    logic [IW-1:0]     top_q;
    logic              arb_fire;
    logic [IW-1:0]     win_idx;
    logic [N-1:0]      win_onehot;
    logic [LFSR_W-1:0] lfsr_val;
    logic [IW-1:0]     rand_start;
    logic [IW-1:0]     rot_idx, rnd_idx, lru_idx;
    logic              rot_hit, rnd_hit, lru_hit;

    assign mode       = arb_mode_e'(mode_i);
    assign arb_fire   = !busy_q && (grant_q == '0) && (req_i != '0);
    assign rand_start = IW'(32'(lfsr_val) % N);

    arb_lfsr u_lfsr (
        .clk     (clk),
        .rst     (rst),
        .value_o (lfsr_val)
    );

    arb_scan_pick #(.N(N), .IW(IW)) u_rot_pick (
        .start_i (top_q),
        .req_i   (req_i),
        .idx_o   (rot_idx),
        .hit_o   (rot_hit)
    );

    arb_scan_pick #(.N(N), .IW(IW)) u_rnd_pick (
        .start_i (rand_start),
        .req_i   (req_i),
        .idx_o   (rnd_idx),
        .hit_o   (rnd_hit)
    );

    arb_lru_list #(.N(N), .IW(IW)) u_lru (
        .clk    (clk),
        .rst    (rst),
        .req_i  (req_i),
        .upd_i  (arb_fire),
        .win_i  (win_idx),
        .pick_o (lru_idx),
        .hit_o  (lru_hit)
    );

    always_comb begin
        unique case (mode)
            MODE_LRU:    win_idx = lru_idx;
            MODE_RANDOM: win_idx = rnd_idx;
            default:     win_idx = rot_idx;
        endcase
        win_onehot          = '0;
        win_onehot[win_idx] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            grant_q <= '0;
            busy_q  <= 1'b0;
            top_q   <= '0;
        end else if (grant_q != '0) begin
            if ((req_i & grant_q) != '0) begin
                busy_q <= 1'b1;
            end else begin
                grant_q <= '0;
                busy_q  <= 1'b0;
            end
        end else if (arb_fire) begin
            grant_q <= win_onehot;
            if (is_rotating(mode))
                top_q <= (top_q == '0) ? IW'(N - 1) : top_q - 1'b1;
        end
    end

    assign grant_o = grant_q;
    assign busy_o  = busy_q;

    // R2: never more than one master granted
    a_r2_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant_q));
    // R2: a fresh grant goes to a master that was requesting
    a_r2_grant_to_requester: assert property (@(posedge clk) disable iff (rst)
        (grant_q != '0 && $past(grant_q) == '0) |-> (($past(req_i) & grant_q) != '0));
    // R2: every selector finds a winner whenever a request is present
    a_r2_pick_hits: assert property (@(posedge clk) disable iff (rst)
        (req_i != '0) |-> (rot_hit && rnd_hit && lru_hit));
    // R3: a new grant only follows an idle bus
    a_r3_idle_before_grant: assert property (@(posedge clk) disable iff (rst)
        (grant_q != '0 && $past(grant_q) == '0) |-> !$past(busy_q));
    // R3: busy never stands without an owner
    a_r3_busy_has_owner: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> (grant_q != '0));
    // R4 / R9: a held request keeps its grant, whatever the mode input does
    a_r4_hold: assert property (@(posedge clk) disable iff (rst)
        (grant_q != '0 && (req_i & grant_q) != '0) |=> (grant_q == $past(grant_q) && busy_q));
    // R5: release clears grant and busy together
    a_r5_release: assert property (@(posedge clk) disable iff (rst)
        (grant_q != '0 && (req_i & grant_q) == '0) |=> (grant_q == '0 && !busy_q));
endmodule

// File: tb/shared_bus_arbiter_tb_top.sv
module shared_bus_arbiter_tb_top;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [1:0]   mode_i = 2'b00;
    logic [N-1:0] req_i = '0;
    logic [N-1:0] grant_o;
    logic         busy_o;

    always #10 clk = ~clk;  // 50 MHz

    shared_bus_arbiter #(.N_MASTERS(N)) dut_i (
        .clk     (clk),
        .rst     (rst),
        .mode_i  (mode_i),
        .req_i   (req_i),
        .grant_o (grant_o),
        .busy_o  (busy_o)
    );

    int checks = 0;
    int failures = 0;

    typedef struct {
        logic [N-1:0] value;
        logic         exact;
        string        tag;
    } exp_t;
    exp_t exp_q[$];

    // reference priority state
    int m_top = 0;
    int m_lru[N];
    int win_count[N];

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    function automatic logic [N-1:0] model_arb(input logic [N-1:0] mask, input logic [1:0] m);
        int w = -1;
        int p = 0;
        if (m == 2'b01) begin
            for (int k = 0; k < N && w < 0; k++) if (mask[m_lru[k]]) w = m_lru[k];
        end else begin
            for (int k = 0; k < N && w < 0; k++) if (mask[(m_top + k) % N]) w = (m_top + k) % N;
        end
        if (m == 2'b00 || m == 2'b11) m_top = (m_top + N - 1) % N;
        for (int k = 0; k < N; k++) if (m_lru[k] == w) p = k;
        for (int k = p; k < N - 1; k++) m_lru[k] = m_lru[k+1];
        m_lru[N-1] = w;
        return (N)'(1) << w;
    endfunction

    // random-mode LRU update with the actually granted index
    function automatic void model_lru_touch(input int w);
        int p = 0;
        for (int k = 0; k < N; k++) if (m_lru[k] == w) p = k;
        for (int k = p; k < N - 1; k++) m_lru[k] = m_lru[k+1];
        m_lru[N-1] = w;
    endfunction

    // monitor: compare every fresh grant with the scoreboard
    logic [N-1:0] prev_grant = '0;
    always @(negedge clk) begin
        if (!rst) begin
            if (grant_o != '0 && prev_grant == '0) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R2 unexpected grant", grant_o, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    if (e.exact)
                        check(grant_o == e.value, e.tag, grant_o, e.value);
                    else
                        check($onehot(grant_o) && ((grant_o & e.value) != '0), e.tag, grant_o, e.value);
                end
            end
            prev_grant = grant_o;
        end
    end

    // driver: one full tenure
    task automatic tenure(input logic [N-1:0] mask, input logic [1:0] m, input int hold,
                          input bit flip_mode, input bit early_drop, input string tag);
        exp_t e;
        logic [N-1:0] g;
        @(negedge clk);
        mode_i = m;
        req_i  = mask;
        e.tag  = tag;
        if (m == 2'b10) begin
            e.value = mask;
            e.exact = ($countones(mask) == 1);
        end else begin
            e.value = model_arb(mask, m);
            e.exact = 1'b1;
        end
        exp_q.push_back(e);
        @(negedge clk);
        g = grant_o;
        if (m == 2'b10) begin
            for (int k = 0; k < N; k++) if (g[k]) begin win_count[k]++; model_lru_touch(k); end
        end
        check(busy_o == 1'b0, "R4 busy low in first grant cycle", busy_o, 0);
        if (early_drop) begin
            req_i = '0;
            @(negedge clk);
            check(grant_o == '0 && busy_o == 1'b0, "R5 early drop clears grant, busy never rises",
                  {grant_o, 3'b0, busy_o}, 0);
            return;
        end
        @(negedge clk);
        check(busy_o == 1'b1, "R4 busy high after first grant cycle", busy_o, 1);
        for (int i = 0; i < hold; i++) begin
            if (flip_mode && i == 0) mode_i = ~m;
            req_i = '1;  // others ask too; must not disturb the tenure
            @(negedge clk);
            check(grant_o == g && busy_o == 1'b1, flip_mode ? "R9 tenure kept across mode change" : "R3 grant stable while busy",
                  grant_o, g);
        end
        req_i = '0;
        @(negedge clk);
        check(grant_o == '0 && busy_o == 1'b0, "R5 release clears grant and busy", {grant_o, 3'b0, busy_o}, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL R2 watchdog expired actual=hung expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int k = 0; k < N; k++) begin m_lru[k] = k; win_count[k] = 0; end
        req_i = '1;
        repeat (3) @(negedge clk);
        check(grant_o == '0 && busy_o == 1'b0, "R1 reset state", {grant_o, 3'b0, busy_o}, 0);
        req_i = '0;
        rst = 1'b0;
        @(negedge clk);
        check(grant_o == '0 && busy_o == 1'b0, "R1 idle after reset", {grant_o, 3'b0, busy_o}, 0);

        // R6 rotating order: top 0, then 3, then 2, ...
        tenure(4'b1111, 2'b00, 2, 0, 0, "R6 rotate all request");
        tenure(4'b1010, 2'b00, 1, 0, 0, "R6 rotate partial");
        tenure(4'b0011, 2'b00, 1, 0, 0, "R6 rotate wrap");
        tenure(4'b0100, 2'b00, 1, 0, 0, "R6 rotate single");
        // R10 alternate code shares the rotating state
        tenure(4'b1111, 2'b11, 1, 0, 0, "R10 mode 11 rotates");
        tenure(4'b0110, 2'b11, 1, 0, 0, "R10 mode 11 partial");
        // R7 LRU order built up by the grants above
        tenure(4'b1111, 2'b01, 1, 0, 0, "R7 lru all request");
        tenure(4'b1111, 2'b01, 1, 0, 0, "R7 lru second");
        tenure(4'b0101, 2'b01, 2, 0, 0, "R7 lru partial");
        tenure(4'b1001, 2'b01, 1, 0, 0, "R7 lru pair");
        // R5 early drop, R9 mode change mid tenure
        tenure(4'b0010, 2'b00, 0, 0, 1, "R2 early-drop grant");
        tenure(4'b1100, 2'b01, 2, 1, 0, "R9 lru with mode flip");
        tenure(4'b1100, 2'b00, 2, 1, 0, "R9 rotate with mode flip");
        // R8 random mode
        for (int i = 0; i < 48; i++)
            tenure(4'b1111, 2'b10, i % 3, 0, 0, "R8 random winner is a requester");
        tenure(4'b0100, 2'b10, 1, 0, 0, "R8 random single requester");
        for (int k = 0; k < N; k++)
            check(win_count[k] > 0, "R8 every master wins in random mode", win_count[k], 1);
        // back to deterministic modes after random grants
        tenure(4'b1111, 2'b01, 1, 0, 0, "R7 lru after random");
        tenure(4'b1011, 2'b00, 1, 0, 0, "R6 rotate after random");

        repeat (2) @(negedge clk);
        check(exp_q.size() == 0, "R2 every expected grant seen", exp_q.size(), 0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule